// File: doc/BRIEF.md
# Serial Segment-Data Receiver with Mode Control

This block takes frames from a three-wire serial link (enable, serial clock, data) and loads them into one of two places: a 4-bit mode register, or a bank of four segment shift registers of 50 bits each. A select line, sampled when the enable line rises, decides which of the two a frame goes to. The mode word names the target of later data frames. It can pick one shift register, chain all four into a single 200-bit path, or clear every shift register at once. Nothing a frame carries reaches the outputs before the enable line falls. At that edge the new mode takes effect, or the targeted register contents are copied into the output latches that drive the display logic.

Frame length is free. Both the mode register and the shift registers are sliding windows. A long frame keeps only its final bits. A short frame pushes the older contents up, so they keep their most recent part. After the supply-good input rises, a cycle-counted power-on sequence holds the receiver idle until a ready flag rises. A refresh monitor raises a flag if a round that latches all four registers takes longer than a set window.

All serial inputs are asynchronous to the system clock. They are synchronised with two flops, and their edges are detected in the system clock domain.

Top module: `seg_serial_rx`

## Requirements
- R1: While `pwr_good` is low, `seg_out` and `mode_out` are zero (mode 0000 selects nothing), and `rdy` and `refresh_late` are low.
- R2: `rdy` rises exactly RESET_CYCLES system clock edges after `pwr_good` rises and then stays high. A frame whose enable rises before `rdy` is high is ignored completely: the mode register does not shift and no output changes.
- R3: The level of `ser_sel` when `ser_ce` rises fixes the frame type: 1 for a mode frame, 0 for a data frame. Data bits are taken on each rising edge of `ser_clk` while `ser_ce` is high.
- R4: Each mode bit shifts into the LSB of the 4-bit mode register, so the first bit of a 4-bit frame ends up as the MSB. A frame of fewer than 4 bits leaves the older bits in the upper positions. A frame of more than 4 bits leaves only its last 4 bits.
- R5: Mode codes 0001 to 0100 select shift register 1 to 4. Register r appears at `seg_out[200-50r +: 50]`. After exactly 50 bits, the first bit sent sits at the MSB of that slice and the last bit at its LSB.
- R6: A data frame shorter than 50 bits keeps the newest older bits in the upper positions of the selected register. A longer frame keeps only its final 50 bits. The other registers and their output slices are unchanged.
- R7: Mode 1010 chains the registers 1-2-3-4 into one 200-bit path. After 200 bits the first bit is at `seg_out[199]` and the last is at `seg_out[0]`, and all four slices are latched.
- R8: The end of a mode frame that loads 1111 clears all four shift registers. The output latches keep their values.
- R9: `seg_out` and `mode_out` change only when a frame ends with the falling edge of `ser_ce`. They stay unchanged while a frame is in progress.
- R10: A data frame sent while the mode is 0000 or any code other than 0001-0100 and 1010 shifts nothing and latches nothing.
- R11: A refresh round opens at the first data latch after the previous round closed, and closes when all four registers have been latched. If a round stays open for REFRESH_CYCLES clock cycles, `refresh_late` goes high. Closing a round clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good indication, low resets the block asynchronously |
| ser_ce | input | 1 | Serial frame enable, high during a frame |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_sel | input | 1 | Frame type, sampled at enable rise: 1 mode, 0 data |
| rdy | output | 1 | Power-on sequence finished, frames accepted |
| mode_out | output | 4 | Mode code currently in effect |
| seg_out | output | 200 | Output latches, register 1 in the top 50 bits |
| refresh_late | output | 1 | Refresh round exceeded its window |

## Verification
Each serial pin passes through two synchroniser flops and one edge-detect stage, so an update caused by the enable line falling shows on `seg_out` or `mode_out` after the third system clock edge. The bench waits eight cycles after every frame before it compares. It holds each data level for three cycles before a serial clock rise, which keeps each bit clear of the synchroniser delay. `rdy` is checked two edges before and two edges after the RESET_CYCLES-th edge. The unchanged-during-frame checks are sampled halfway through each frame. `refresh_late` is sampled well inside and well beyond its window, so the check does not depend on exact cycle alignment.

// File: rtl/seg_serial_rx.sv
`timescale 1ns/1ps
module seg_serial_rx #(
  parameter int SEG_BITS       = 50,
  parameter int NUM_REGS       = 4,
  parameter int RESET_CYCLES   = 200000,
  parameter int REFRESH_CYCLES = 3000000
) (
  input  logic                         clk,
  input  logic                         pwr_good,
  input  logic                         ser_ce,
  input  logic                         ser_clk,
  input  logic                         ser_dat,
  input  logic                         ser_sel,
  output logic                         rdy,
  output logic [3:0]                   mode_out,
  output logic [SEG_BITS*NUM_REGS-1:0] seg_out,
  output logic                         refresh_late
);
  localparam int TOT = SEG_BITS * NUM_REGS;
  localparam int RCW = $clog2(RESET_CYCLES + 1);
  localparam int WCW = $clog2(REFRESH_CYCLES + 1);
  localparam logic [3:0] CODE_CHAIN = 4'b1010;
  localparam logic [3:0] CODE_CLEAR = 4'b1111;

  logic [2:0] ce_s, ck_s, dt_s, sl_s;
  logic [RCW-1:0] rst_cnt;
  logic in_frame, is_mode;
  logic [3:0] mode_sr, mode_q;
  logic [TOT-1:0] sh, seg_q;
  logic [NUM_REGS-1:0] pick, lat_mask, done, nxt_done;
  logic [WCW-1:0] win;
  logic chain, mode_ok, commit;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      ce_s <= '0; ck_s <= '0; dt_s <= '0; sl_s <= '0;
    end else begin
      ce_s <= {ce_s[1:0], ser_ce};
      ck_s <= {ck_s[1:0], ser_clk};
      dt_s <= {dt_s[1:0], ser_dat};
      sl_s <= {sl_s[1:0], ser_sel};
    end

  wire ce_rise   = ce_s[1] & ~ce_s[2];
  wire ce_fall   = ~ce_s[1] & ce_s[2];
  wire ck_rise   = ck_s[1] & ~ck_s[2];
  wire din       = dt_s[1];
  wire frame_end = in_frame & ce_fall;
  wire bit_evt   = in_frame & ce_s[1] & ck_rise;

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) pick[r] = (mode_q == 4'(r + 1));
    chain    = (mode_q == CODE_CHAIN);
    mode_ok  = chain | (|pick);
    lat_mask = chain ? '1 : pick;
    commit   = frame_end & ~is_mode & mode_ok;
    nxt_done = done | (commit ? lat_mask : '0);
  end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      rst_cnt <= '0;
      rdy     <= 1'b0;
    end else if (!rdy) begin
      if (rst_cnt == RCW'(RESET_CYCLES - 1)) rdy <= 1'b1;
      else rst_cnt <= rst_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      in_frame <= 1'b0;
      is_mode  <= 1'b0;
    end else if (rdy && ce_rise) begin
      in_frame <= 1'b1;
      is_mode  <= sl_s[1];
    end else if (ce_fall) begin
      in_frame <= 1'b0;
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      mode_sr <= '0;
      mode_q  <= '0;
    end else begin
      if (bit_evt && is_mode) mode_sr <= {mode_sr[2:0], din};
      if (frame_end && is_mode) mode_q <= mode_sr;
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) sh <= '0;
    else if (frame_end && is_mode && mode_sr == CODE_CLEAR) sh <= '0;
    else if (bit_evt && !is_mode) begin
      if (chain) sh <= {sh[TOT-2:0], din};
      else
        for (int r = 0; r < NUM_REGS; r++)
          if (pick[r])
            sh[TOT-SEG_BITS*(r+1) +: SEG_BITS] <= {sh[TOT-SEG_BITS*(r+1) +: SEG_BITS-1], din};
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) seg_q <= '0;
    else if (frame_end && !is_mode) begin
      if (chain) seg_q <= sh;
      else
        for (int r = 0; r < NUM_REGS; r++)
          if (pick[r])
            seg_q[TOT-SEG_BITS*(r+1) +: SEG_BITS] <= sh[TOT-SEG_BITS*(r+1) +: SEG_BITS];
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      done         <= '0;
      win          <= '0;
      refresh_late <= 1'b0;
    end else if (&nxt_done) begin
      done         <= '0;
      win          <= '0;
      refresh_late <= 1'b0;
    end else begin
      done <= nxt_done;
      if (|nxt_done) begin
        if (win == WCW'(REFRESH_CYCLES - 1)) refresh_late <= 1'b1;
        else win <= win + 1'b1;
      end
    end

  assign mode_out = mode_q;
  assign seg_out  = seg_q;
endmodule

module seg_serial_rx_chk #(parameter int TOT = 200) (
  input logic           clk,
  input logic           pwr_good,
  input logic           rdy,
  input logic           frame_end,
  input logic           is_mode,
  input logic           mode_ok,
  input logic [3:0]     mode_out,
  input logic [TOT-1:0] seg_out
);
  assert_idle_before_ready_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    !rdy |-> (seg_out == '0 && mode_out == 4'd0));
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    rdy |=> rdy);
  assert_seg_only_at_end_R9: assert property (@(posedge clk) disable iff (!pwr_good)
    !frame_end |=> $stable(seg_out));
  assert_mode_only_at_end_R9: assert property (@(posedge clk) disable iff (!pwr_good)
    !(frame_end && is_mode) |=> $stable(mode_out));
  assert_undefined_ignored_R10: assert property (@(posedge clk) disable iff (!pwr_good)
    (frame_end && !is_mode && !mode_ok) |=> $stable(seg_out));
endmodule

bind seg_serial_rx seg_serial_rx_chk #(.TOT(TOT)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .rdy(rdy), .frame_end(frame_end),
  .is_mode(is_mode), .mode_ok(mode_ok), .mode_out(mode_out), .seg_out(seg_out));

// File: tb/test_seg_serial_rx.sv
`timescale 1ns/1ps
module test_seg_serial_rx;
  localparam int W = 50, N = 4, TOT = W * N, RST = 400, WIN = 2000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic pwr_good = 1'b0, ser_ce = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, ser_sel = 1'b0;
  logic rdy, refresh_late;
  logic [3:0] mode_out;
  logic [TOT-1:0] seg_out;

  seg_serial_rx #(.SEG_BITS(W), .NUM_REGS(N), .RESET_CYCLES(RST), .REFRESH_CYCLES(WIN)) i_seg_serial_rx (
    .clk(clk), .pwr_good(pwr_good), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_sel(ser_sel), .rdy(rdy), .mode_out(mode_out), .seg_out(seg_out), .refresh_late(refresh_late));

  int nvec = 0, nbad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [TOT-1:0] sh_m = '0, out_m = '0;
  logic [3:0] msr_m = '0, mode_m = '0;
  bit acc_m = 1'b0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] gen(input int unsigned seed);
    logic [255:0] p;
    int unsigned x = seed | 1;
    for (int i = 0; i < 256; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      p[i] = x[7];
    end
    return p;
  endfunction

  function automatic logic [255:0] mpat(input logic [3:0] v);
    logic [255:0] p = '0;
    for (int i = 0; i < 4; i++) p[i] = v[3-i];
    return p;
  endfunction

  task automatic frame(input bit sel, input int n, input logic [255:0] pat);
    logic [TOT-1:0] o0 = out_m;
    logic [3:0] m0 = mode_m;
    int base;
    @(negedge clk);
    ser_sel = sel; ser_ce = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_dat = pat[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      if (acc_m) begin
        if (sel) msr_m = {msr_m[2:0], pat[i]};
        else if (mode_m == 4'b1010) sh_m = {sh_m[TOT-2:0], pat[i]};
        else if (mode_m >= 4'd1 && mode_m <= 4'd4) begin
          base = TOT - W * int'(mode_m);
          sh_m[base +: W] = {sh_m[base +: W-1], pat[i]};
        end
      end
      if (i == n / 2) begin
        chk("R9 seg mid-frame", 256'(seg_out), 256'(o0));
        chk("R9 mode mid-frame", 256'(mode_out), 256'(m0));
      end
    end
    ser_ce = 1'b0;
    repeat (8) @(negedge clk);
    if (acc_m) begin
      if (sel) begin
        mode_m = msr_m;
        if (msr_m == 4'b1111) sh_m = '0;
      end else if (mode_m == 4'b1010) out_m = sh_m;
      else if (mode_m >= 4'd1 && mode_m <= 4'd4) begin
        base = TOT - W * int'(mode_m);
        out_m[base +: W] = sh_m[base +: W];
      end
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int t0;
    int lens[6] = '{50, 1, 17, 49, 51, 77};
    int mlens[6] = '{4, 1, 2, 3, 5, 7};
    logic [255:0] p, e;

    repeat (5) @(negedge clk);
    chk("R1 seg reset", 256'(seg_out), 256'(0));
    chk("R1 mode reset", 256'(mode_out), 256'(0));
    chk("R1 rdy reset", 256'(rdy), 256'(0));
    chk("R1 late reset", 256'(refresh_late), 256'(0));

    pwr_good = 1'b1; t0 = cyc;
    frame(1'b1, 4, mpat(4'b0001));
    chk("R2 early frame ignored", 256'(mode_out), 256'(0));
    while (cyc - t0 < RST - 2) @(negedge clk);
    chk("R2 rdy still low", 256'(rdy), 256'(0));
    while (cyc - t0 < RST + 2) @(negedge clk);
    chk("R2 rdy high", 256'(rdy), 256'(1));
    acc_m = 1'b1;

    for (int k = 0; k < 6; k++) begin
      frame(1'b1, mlens[k], gen(100 + k));
      chk("R4 mode window", 256'(mode_out), 256'(mode_m));
    end
    frame(1'b1, 2, mpat(4'b0100) >> 2);
    chk("R4 short frame keeps upper", 256'(mode_out), 256'(mode_m));

    for (int r = 1; r <= 4; r++) begin
      frame(1'b1, 4, mpat(4'(r)));
      chk("R3 mode frame select", 256'(mode_out), 256'(r));
      for (int k = 0; k < 6; k++) begin
        p = gen(r * 37 + k);
        frame(1'b0, lens[k], p);
        chk("R6 data window", 256'(seg_out), 256'(out_m));
        if (k == 0) begin
          e = '0;
          for (int i = 0; i < W; i++) e[W-1-i] = p[i];
          chk("R5 slice order", 256'(seg_out[TOT-W*r +: W]), e);
        end
      end
    end

    frame(1'b1, 4, mpat(4'b1010));
    p = gen(777);
    frame(1'b0, 200, p);
    e = '0;
    for (int i = 0; i < TOT; i++) e[TOT-1-i] = p[i];
    chk("R7 chain 200", 256'(seg_out), e);
    frame(1'b0, 230, gen(778));
    chk("R7 chain long", 256'(seg_out), 256'(out_m));

    frame(1'b1, 4, mpat(4'b1111));
    chk("R8 latches kept", 256'(seg_out), 256'(out_m));
    frame(1'b1, 4, mpat(4'b0001));
    frame(1'b0, 1, 256'(1));
    chk("R8 register cleared", 256'(seg_out[TOT-W +: W]), 256'(1));
    chk("R8 model agrees", 256'(seg_out), 256'(out_m));

    frame(1'b1, 4, mpat(4'b0000));
    frame(1'b0, 30, gen(901));
    chk("R10 none mode ignored", 256'(seg_out), 256'(out_m));
    frame(1'b1, 4, mpat(4'b0111));
    frame(1'b0, 30, gen(902));
    chk("R10 undefined mode ignored", 256'(seg_out), 256'(out_m));
    frame(1'b1, 4, mpat(4'b0010));
    frame(1'b0, 1, 256'(0));
    chk("R10 no shift happened", 256'(seg_out), 256'(out_m));

    frame(1'b1, 4, mpat(4'b1010));
    frame(1'b0, 3, gen(55));
    chk("R11 round closed", 256'(refresh_late), 256'(0));
    frame(1'b1, 4, mpat(4'b0001));
    frame(1'b0, 3, gen(56));
    chk("R11 inside window", 256'(refresh_late), 256'(0));
    repeat (WIN + 100) @(negedge clk);
    chk("R11 window expired", 256'(refresh_late), 256'(1));
    frame(1'b1, 4, mpat(4'b1010));
    frame(1'b0, 1, 256'(1));
    chk("R11 cleared on close", 256'(refresh_late), 256'(0));
    chk("R7 single bit chain", 256'(seg_out), 256'(out_m));

    summary();
  end
endmodule